// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It pops frame words from a transmit queue, shifts them out MSB first on `mosi` while capturing `miso`, and pushes each completed frame to a receive queue. Both queues sit outside the block: the block only sees a valid/data pair on the transmit side and a one-cycle push strobe on the receive side.

Static configuration inputs select the clock polarity and phase (SPI modes 0 to 3), a frame width of 4, 8 or 16 bits, a 16-bit clock divider and a slave-select mask. Configuration is changed only while the enable input is low. The chip selects follow the mask directly, so software frames a transaction by setting the mask, streaming words, polling `busy` low and clearing the mask. Dropping the enable aborts any frame at once.

Top module: `spi_shift_master`

## Requirements
- R1: `cfg_frame_size` code 0 gives 4-bit frames, code 1 gives 8-bit frames, codes 2 and 3 give 16-bit frames; exactly one word is popped and one word is pushed per frame.
- R2: The low frame-width bits of `tx_data` are sent MSB first on `mosi`; higher bits of the word have no effect on the line.
- R3: Whenever `busy` is low, `sclk` equals `cfg_cpol`.
- R4: With `cfg_cpha` = 0 the first data bit is on `mosi` before the first `sclk` edge and `miso` is captured on odd edges (1st, 3rd, ...); with `cfg_cpha` = 1 data is launched on odd edges and captured on even edges.
- R5: The effective divider is `cfg_divider` with bit 0 cleared, raised to 2 if smaller; `sclk` toggles every (effective divider / 2) clock cycles during a frame, the first toggle coming that many cycles after the pop cycle.
- R6: One clock after the last `sclk` edge of a frame, `rx_push` is high for exactly one cycle with the received bits in the low bits of `rx_data` and zeros above; the push does not wait for any acceptance.
- R7: If a word is available on the cycle of a frame's last edge it is popped in that cycle and the next frame follows with no idle gap; with no word available the engine stops and `sclk` rests at `cfg_cpol`.
- R8: `cs_n[i]` is the inverse of `cfg_slave_mask[i]` registered once, independent of transfers and of the enable; a zero mask raises both selects.
- R9: `busy` is high while a frame is in progress or while `cfg_enable` and `tx_valid` are both high.
- R10: While `cfg_enable` is low no word is popped, and from the next clock on `sclk` is at `cfg_cpol`, `mosi` is low and no push is raised; a frame in progress is discarded.
- R11: `tx_ready` (the pop strobe) is high only when `cfg_enable` and `tx_valid` are high and the engine is either idle or on the last edge of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Transfer enable; configuration changes only while low |
| cfg_cpol | input | 1 | Idle level of `sclk` |
| cfg_cpha | input | 1 | 0: capture on odd edges, 1: capture on even edges |
| cfg_frame_size | input | 2 | Frame width code (0: 4, 1: 8, 2/3: 16 bits) |
| cfg_divider | input | DIV_W | Core clocks per `sclk` period before even/floor rounding |
| cfg_slave_mask | input | NUM_CS | One bit per slave select, 1 selects |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 16 | Word at the head of the transmit queue |
| tx_ready | output | 1 | Pop strobe for the transmit queue |
| rx_push | output | 1 | Push strobe for the receive queue |
| rx_data | output | 16 | Received frame, zero-extended |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low slave selects |
| busy | output | 1 | Frame in progress or data pending |

## Verification
The bench builds the block with its default parameters, a 16-bit divider and two selects, and drives divider values of 0, 4, 6 and 7 so that the floor of two and the clearing of an odd low bit are both reached with short serial periods. All four frame-size codes and all four clock modes are used, half of them with `miso` looped back from `mosi` so that received words can be predicted from sent words, the rest with a pseudo-random `miso` that the cycle model samples on the same edges. Back-to-back words, a queue that runs dry, an abort in the middle of a 16-bit frame and mask changes during idle and active periods bring the frame-boundary and chip-select cases within reach.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  localparam int WORD_W = 16;
  localparam int BITS_W = 5;
  localparam int EDGE_W = BITS_W + 1;

  typedef enum logic [1:0] {
    FSZ_4   = 2'd0,
    FSZ_8   = 2'd1,
    FSZ_16  = 2'd2,
    FSZ_16B = 2'd3
  } frame_code_e;

  // Number of bits in a frame for a given size code.
  function automatic logic [BITS_W-1:0] frame_bits(input logic [1:0] code);
    case (frame_code_e'(code))
      FSZ_4:   frame_bits = BITS_W'(4);
      FSZ_8:   frame_bits = BITS_W'(8);
      default: frame_bits = BITS_W'(16);
    endcase
  endfunction

  // Core clocks per half serial period: even divider, floor of two.
  function automatic int unsigned half_period(input int unsigned div);
    int unsigned even_div;
    even_div = div & 32'hFFFF_FFFE;
    if (even_div < 2) even_div = 2;
    half_period = even_div / 2;
  endfunction

  // Places the low n bits of a word at the top of the shift register.
  function automatic logic [WORD_W-1:0] align_msb(input logic [WORD_W-1:0] w,
                                                  input logic [BITS_W-1:0] n);
    align_msb = w << (WORD_W - int'(n));
  endfunction

  // Mask with the low n bits set.
  function automatic logic [WORD_W-1:0] low_mask(input logic [BITS_W-1:0] n);
    logic [WORD_W:0] wide;
    wide = ((WORD_W+1)'(1) << n) - (WORD_W+1)'(1);
    low_mask = wide[WORD_W-1:0];
  endfunction

endpackage

// File: rtl/spi_sclk_timer.sv
module spi_sclk_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divider,
  output logic             edge_tick
);
  import spi_shift_pkg::*;

  localparam int CNT_W = DIV_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;

  always_comb begin
    half_m1   = CNT_W'(half_period(32'(divider)) - 1);
    edge_tick = run && (cnt_q == half_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || edge_tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              enable,
  input  logic                              cpol,
  input  logic                              cpha,
  input  logic [1:0]                        frame_code,
  input  logic                              tx_valid,
  input  logic [spi_shift_pkg::WORD_W-1:0]  tx_data,
  input  logic                              miso,
  input  logic                              edge_tick,
  output logic                              run,
  output logic                              tx_pop,
  output logic                              frame_done,
  output logic                              active,
  output logic                              sclk,
  output logic                              mosi,
  output logic                              rx_push,
  output logic [spi_shift_pkg::WORD_W-1:0]  rx_data
);
  import spi_shift_pkg::*;

  logic              active_q;
  logic              lvl_q;
  logic [EDGE_W-1:0] edge_q;
  logic [BITS_W-1:0] nbits_q;
  logic [WORD_W-1:0] tx_sr_q;
  logic [WORD_W-1:0] rx_sr_q;
  logic              mosi_q;
  logic              rx_push_q;
  logic [WORD_W-1:0] rx_data_q;

  logic [EDGE_W-1:0] edge_num;
  logic              odd_edge;
  logic              last_edge;
  logic              launch;
  logic              capture;
  logic              load;
  logic [WORD_W-1:0] rx_next;
  logic [BITS_W-1:0] load_bits;
  logic [WORD_W-1:0] load_word;

  always_comb begin
    run        = active_q && enable;
    edge_num   = edge_q + EDGE_W'(1);
    odd_edge   = edge_num[0];
    last_edge  = (edge_num == {nbits_q, 1'b0});
    capture    = edge_tick && (cpha ? !odd_edge : odd_edge);
    launch     = edge_tick && (cpha ? odd_edge : (!odd_edge && !last_edge));
    frame_done = edge_tick && last_edge;
    load       = enable && tx_valid && (!active_q || frame_done);
    rx_next    = capture ? {rx_sr_q[WORD_W-2:0], miso} : rx_sr_q;
    load_bits  = frame_bits(frame_code);
    load_word  = align_msb(tx_data, load_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      lvl_q     <= 1'b0;
      edge_q    <= '0;
      nbits_q   <= BITS_W'(8);
      tx_sr_q   <= '0;
      rx_sr_q   <= '0;
      mosi_q    <= 1'b0;
      rx_push_q <= 1'b0;
      rx_data_q <= '0;
    end else if (!enable) begin
      active_q  <= 1'b0;
      lvl_q     <= 1'b0;
      edge_q    <= '0;
      mosi_q    <= 1'b0;
      rx_push_q <= 1'b0;
    end else begin
      rx_push_q <= frame_done;
      if (frame_done) begin
        rx_data_q <= rx_next & low_mask(nbits_q);
      end
      if (edge_tick) begin
        lvl_q   <= ~lvl_q;
        edge_q  <= edge_num;
        rx_sr_q <= rx_next;
        if (launch) begin
          mosi_q  <= tx_sr_q[WORD_W-1];
          tx_sr_q <= tx_sr_q << 1;
        end
      end
      if (load) begin
        active_q <= 1'b1;
        lvl_q    <= 1'b0;
        edge_q   <= '0;
        nbits_q  <= load_bits;
        rx_sr_q  <= '0;
        if (cpha) begin
          tx_sr_q <= load_word;
        end else begin
          mosi_q  <= load_word[WORD_W-1];
          tx_sr_q <= load_word << 1;
        end
      end else if (frame_done) begin
        active_q <= 1'b0;
      end
    end
  end

  assign tx_pop  = load;
  assign active  = active_q;
  assign sclk    = cpol ^ lvl_q;
  assign mosi    = mosi_q;
  assign rx_push = rx_push_q;
  assign rx_data = rx_data_q;

endmodule

// File: rtl/spi_cs_driver.sv
module spi_cs_driver #(
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CS-1:0] slave_mask,
  output logic [NUM_CS-1:0] cs_n
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
    logic sel_n_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_n_q <= 1'b1;
      else        sel_n_q <= ~slave_mask[i];
    end
    assign cs_n[i] = sel_n_q;
  end

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master #(
  parameter int DIV_W  = 16,
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [1:0]        cfg_frame_size,
  input  logic [DIV_W-1:0]  cfg_divider,
  input  logic [NUM_CS-1:0] cfg_slave_mask,
  input  logic              tx_valid,
  input  logic [15:0]       tx_data,
  output logic              tx_ready,
  output logic              rx_push,
  output logic [15:0]       rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n,
  output logic              busy
);

  // Named internal events, observed by the bound checker.
  logic edge_tick;
  logic frame_done;
  logic shift_run;
  logic shift_active;

  spi_sclk_timer #(.DIV_W(DIV_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (shift_run),
    .divider   (cfg_divider),
    .edge_tick (edge_tick)
  );

  spi_frame_shifter u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cfg_enable),
    .cpol       (cfg_cpol),
    .cpha       (cfg_cpha),
    .frame_code (cfg_frame_size),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .miso       (miso),
    .edge_tick  (edge_tick),
    .run        (shift_run),
    .tx_pop     (tx_ready),
    .frame_done (frame_done),
    .active     (shift_active),
    .sclk       (sclk),
    .mosi       (mosi),
    .rx_push    (rx_push),
    .rx_data    (rx_data)
  );

  spi_cs_driver #(.NUM_CS(NUM_CS)) u_cs (
    .clk        (clk),
    .rst_n      (rst_n),
    .slave_mask (cfg_slave_mask),
    .cs_n       (cs_n)
  );

  assign busy = shift_active || (cfg_enable && tx_valid);

endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk #(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              cfg_cpol,
  input logic [1:0]        cfg_frame_size,
  input logic [NUM_CS-1:0] cfg_slave_mask,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_push,
  input logic [15:0]       rx_data,
  input logic              sclk,
  input logic              mosi,
  input logic [NUM_CS-1:0] cs_n,
  input logic              busy,
  input logic              frame_done
);

  assert_pop_needs_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (tx_valid && cfg_enable));

  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cfg_cpol));

  assert_pending_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && tx_valid) |-> busy);

  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> ((sclk == cfg_cpol) && !rx_push && !mosi));

  assert_push_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_push);

  assert_push_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);

  assert_nibble_zero_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && cfg_frame_size == 2'd0) |-> (rx_data[15:4] == 12'h000));

  assert_select_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cs_n == ~$past(cfg_slave_mask)));

endmodule

bind spi_shift_master spi_shift_master_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_enable     (cfg_enable),
  .cfg_cpol       (cfg_cpol),
  .cfg_frame_size (cfg_frame_size),
  .cfg_slave_mask (cfg_slave_mask),
  .tx_valid       (tx_valid),
  .tx_ready       (tx_ready),
  .rx_push        (rx_push),
  .rx_data        (rx_data),
  .sclk           (sclk),
  .mosi           (mosi),
  .cs_n           (cs_n),
  .busy           (busy),
  .frame_done     (frame_done)
);

// File: tb/spi_shift_master_bench.sv
`timescale 1ns/1ps
module spi_shift_master_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic        cfg_cpol = 1'b0;
  logic        cfg_cpha = 1'b0;
  logic [1:0]  cfg_frame_size = 2'd1;
  logic [15:0] cfg_divider = 16'd4;
  logic [1:0]  cfg_slave_mask = 2'b00;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = 16'h0;
  logic        tx_ready;
  logic        rx_push;
  logic [15:0] rx_data;
  logic        sclk;
  logic        mosi;
  logic        miso;
  logic [1:0]  cs_n;
  logic        busy;

  logic        loopback = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  assign miso = loopback ? mosi : lfsr[0];

  spi_shift_master u_spi_shift_master (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_frame_size(cfg_frame_size), .cfg_divider(cfg_divider),
    .cfg_slave_mask(cfg_slave_mask), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Arithmetic restated from the requirements.
  function automatic int bits_of(input int code);
    if (code == 0) return 4;
    if (code == 1) return 8;
    return 16;
  endfunction

  function automatic int half_of(input int div);
    int e;
    e = (div / 2) * 2;
    if (e < 2) e = 2;
    return e / 2;
  endfunction

  // Behavioural cycle model.
  int m_active = 0, m_lvl = 0, m_edges = 0, m_n = 8, m_cnt = 0;
  int m_tx = 0, m_rx = 0, m_rxd = 0;
  int m_mosi = 0, m_push = 0, m_cs = 3;
  bit m_popped = 0;
  bit p_tick, p_done, p_load, p_cap, p_launch;

  task automatic predict();
    int k;
    k = m_edges + 1;
    p_tick   = (m_active != 0) && cfg_enable && (m_cnt == half_of(int'(cfg_divider)) - 1);
    p_done   = p_tick && (k == 2 * m_n);
    p_cap    = p_tick && (cfg_cpha ? (k % 2 == 0) : (k % 2 == 1));
    p_launch = p_tick && (cfg_cpha ? (k % 2 == 1) : ((k % 2 == 0) && !p_done));
    p_load   = cfg_enable && tx_valid && ((m_active == 0) || p_done);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_lvl = 0; m_edges = 0; m_cnt = 0; m_mosi = 0;
      m_push = 0; m_rxd = 0; m_cs = 3; m_popped = 0;
    end else begin
      int rx_in, aligned;
      predict();
      m_popped = p_load;
      m_cs = 3 ^ int'(cfg_slave_mask);
      rx_in = p_cap ? (((m_rx << 1) | int'(miso)) & 16'hFFFF) : m_rx;
      if (!cfg_enable) begin
        m_active = 0; m_lvl = 0; m_edges = 0; m_mosi = 0; m_push = 0; m_cnt = 0;
      end else begin
        m_push = p_done ? 1 : 0;
        if (p_done) m_rxd = rx_in & ((1 << m_n) - 1);
        m_cnt = (m_active != 0) ? (p_tick ? 0 : m_cnt + 1) : 0;
        if (p_tick) begin
          m_lvl = 1 - m_lvl;
          m_edges++;
          m_rx = rx_in;
          if (p_launch) begin
            m_mosi = (m_tx >> 15) & 1;
            m_tx = (m_tx << 1) & 16'hFFFF;
          end
        end
        if (p_load) begin
          m_active = 1; m_lvl = 0; m_edges = 0; m_rx = 0;
          m_n = bits_of(int'(cfg_frame_size));
          aligned = (int'(tx_data) << (16 - m_n)) & 16'hFFFF;
          if (cfg_cpha) m_tx = aligned;
          else begin
            m_mosi = (aligned >> 15) & 1;
            m_tx = (aligned << 1) & 16'hFFFF;
          end
        end else if (p_done) m_active = 0;
      end
    end
  end

  // Per-cycle comparison away from the clock edge.
  int got[$];
  int cyc = 0, last_tog = -1, min_gap = 1000000;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      predict();
      chk(tx_ready == p_load, "R11 pop strobe", int'(tx_ready), int'(p_load));
      chk(sclk == (cfg_cpol ^ m_lvl[0]), "R5 sclk timing", int'(sclk), int'(cfg_cpol ^ m_lvl[0]));
      chk(mosi == m_mosi[0], "R4 mosi bit", int'(mosi), m_mosi);
      chk(int'(cs_n) == m_cs, "R8 select", int'(cs_n), m_cs);
      chk(busy == ((m_active != 0) || (cfg_enable && tx_valid)), "R9 busy",
          int'(busy), int'((m_active != 0) || (cfg_enable && tx_valid)));
      chk(rx_push == m_push[0], "R6 push strobe", int'(rx_push), m_push);
      chk(int'(rx_data) == m_rxd, "R6 push data", int'(rx_data), m_rxd);
      if (rx_push) got.push_back(int'(rx_data));
      if (cfg_enable && sclk != prev_sclk) begin
        if (last_tog >= 0 && cyc - last_tog < min_gap) min_gap = cyc - last_tog;
        last_tog = cyc;
      end
      prev_sclk = sclk;
    end
  end

  // Transmit queue and miso source, updated shortly after each edge.
  int q[$];
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (m_popped && q.size() > 0) void'(q.pop_front());
      tx_valid = (q.size() > 0);
      tx_data  = (q.size() > 0) ? 16'(q[0]) : 16'h0;
      lfsr     = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  task automatic setup(input bit pol, input bit pha, input int code, input int div, input bit lb);
    @(posedge clk); #3;
    cfg_enable = 1'b0;
    repeat (2) @(posedge clk);
    #3;
    cfg_cpol = pol; cfg_cpha = pha; cfg_frame_size = 2'(code);
    cfg_divider = 16'(div); loopback = lb;
    got.delete();
    last_tog = -1; min_gap = 1000000;
    @(posedge clk); #3;
    cfg_enable = 1'b1;
  endtask

  task automatic wait_idle();
    @(posedge clk); @(posedge clk);
    do @(negedge clk); while (q.size() != 0 || busy);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_loop(input bit pol, input bit pha, input int code, input int div,
                          input int w0, input int w1, input string req);
    int n;
    setup(pol, pha, code, div, 1'b1);
    q.push_back(w0); q.push_back(w1);
    wait_idle();
    n = bits_of(code);
    chk(got.size() == 2, {req, " R1 frame count"}, got.size(), 2);
    if (got.size() == 2) begin
      chk(got[0] == (w0 & ((1 << n) - 1)), {req, " R2 word0"}, got[0], w0 & ((1 << n) - 1));
      chk(got[1] == (w1 & ((1 << n) - 1)), {req, " R2 word1"}, got[1], w1 & ((1 << n) - 1));
    end
    chk(min_gap == half_of(div), {req, " R5 half period"}, min_gap, half_of(div));
    chk(sclk == pol, {req, " R3 idle level"}, int'(sclk), int'(pol));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 2'b11, "R8 reset selects", int'(cs_n), 3);
    chk(!busy && !rx_push && !tx_ready, "R9 reset quiet", int'(busy), 0);
    chk(sclk == 1'b0, "R3 reset level", int'(sclk), 0);
    @(posedge clk); #3 rst_n = 1'b1;

    // R7 back-to-back frames in every mode and size code.
    run_loop(1'b0, 1'b0, 1, 4,  'h00A5, 'h003C, "m0 8b");
    run_loop(1'b1, 1'b1, 2, 6,  'hBEEF, 'h1234, "m3 16b");
    run_loop(1'b0, 1'b1, 0, 0,  'hFFF9, 'h0006, "m1 4b");
    run_loop(1'b1, 1'b0, 3, 7,  'h8001, 'h7FFE, "m2 16b");

    // Pseudo-random miso, checked by the cycle model (R4, R6).
    setup(1'b1, 1'b0, 1, 7, 1'b0);
    q.push_back('h5A); q.push_back('hC3); q.push_back('h0F);
    wait_idle();
    chk(got.size() == 3, "R1 random frames", got.size(), 3);

    // R10 abort in the middle of a 16-bit frame.
    setup(1'b1, 1'b1, 2, 8, 1'b0);
    q.push_back('hA55A);
    repeat (20) @(posedge clk);
    #3 cfg_enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(sclk == 1'b1, "R10 sclk idle after abort", int'(sclk), 1);
    repeat (30) @(negedge clk);
    chk(got.size() == 0, "R10 no push after abort", got.size(), 0);
    chk(!busy, "R10 not busy", int'(busy), 0);

    // R8 select mask follows the inputs, with or without transfers.
    @(posedge clk); #3 cfg_slave_mask = 2'b01;
    @(negedge clk); @(negedge clk);
    chk(cs_n == 2'b10, "R8 slave0 selected", int'(cs_n), 2);
    setup(1'b0, 1'b0, 1, 4, 1'b1);
    q.push_back('h81);
    repeat (6) @(posedge clk);
    #3 cfg_slave_mask = 2'b10;
    @(negedge clk); @(negedge clk);
    chk(cs_n == 2'b01, "R8 slave1 mid frame", int'(cs_n), 1);
    wait_idle();
    @(posedge clk); #3 cfg_slave_mask = 2'b00;
    @(negedge clk); @(negedge clk);
    chk(cs_n == 2'b11, "R8 zero mask", int'(cs_n), 3);
    chk(got.size() == 1 && got[0] == 'h81, "R7 single word then stop", got.size(), 1);

    repeat (5) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

endmodule